// File: doc/BRIEF.md
# Sync Clock Frequency Decoder with Fallback

This block watches an external synchronization clock, `sync_in`, using a fixed reference clock, `clk`. It decides whether that input is usable. While the sync input qualifies, the switching-clock output `sw_clk` follows the synchronized sync level. Otherwise `sw_clk` follows the internal oscillator input `int_osc`.

The block also picks the internal oscillator setting, which the surrounding converter uses whenever sync is missing. The setting is fixed once per enable, at the end of the first gate window after `en` rises. If that window saw an in-range sync frequency, the setting is decoded from the measured frequency. If not, it is taken from the strap code `strap_sel`. The setting then stays frozen until `en` falls or reset is applied.

Frequency is measured by counting synchronized rising edges of `sync_in` over a gate window of `GATE_CYCLES` reference cycles. The edge count is compared with count thresholds, which are derived at elaboration time from kHz values and the reference frequency `REF_KHZ`. The loss timeout is `2*REF_KHZ/MIN_KHZ` reference cycles, which is two periods of the slowest legal sync clock.

Top module: `sync_freq_decoder`

## Requirements
- R1: While `rst` is high, and one cycle after `en` goes low, `freq_code`, `code_valid`, `code_src` and `sync_active` are 0. `sw_clk` is 0 during reset.
- R2: `sync_active` is set only after two consecutive full gate windows whose counts lie in the legal range. It is therefore still 0 at the end of the first window after enable, and it is 1 at most three windows after a legal sync starts.
- R3: After the last rising edge on `sync_in`, `sync_active` returns to 0 within `2*REF_KHZ/MIN_KHZ` plus 8 reference cycles.
- R4: A measured sync frequency below 400 kHz or above 2640 kHz never sets `sync_active`, and at enable it counts as no sync.
- R5: While `sync_active` is 1, `sw_clk` is the synchronized `sync_in` level. While it is 0, `sw_clk` is `int_osc` registered once.
- R6: `code_valid` rises exactly `GATE_CYCLES`+1 cycles after the first clock edge that sees `en` high, and it stays 0 before that.
- R7: Decoded codes use this encoding: 0 = 500 kHz for sync of 400–600 kHz, 1 = 750 kHz for 600–857 kHz, 2 = 1000 kHz for 857–1200 kHz, 3 = 1500 kHz for 1200–1810 kHz, 4 = 2200 kHz for 1810–2640 kHz. No other value appears.
- R8: A sync frequency inside 570–630, 814–900, 1140–1260 or 1736–1884 kHz may decode to either of the two adjacent codes. Outside those bands the code is exact.
- R9: When no legal sync is measured in the first window, `freq_code` takes `strap_sel`, with values 5 to 7 mapping to 4, and `code_src` is 0.
- R10: Once `code_valid` is 1, `freq_code` and `code_src` do not change while `en` stays high. This holds when sync appears, when it disappears and when `strap_sel` changes.
- R11: When the code is decoded from the measured sync, `code_src` is 1 and `strap_sel` has no effect on `freq_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable. Low clears the latched setting and presence state |
| sync_in | input | 1 | External synchronization clock, asynchronous |
| int_osc | input | 1 | Internal oscillator level used when sync is absent |
| strap_sel | input | 3 | Strap frequency code used when no sync is seen at enable |
| sw_clk | output | 1 | Switching clock: sync or internal oscillator |
| sync_active | output | 1 | Sync input is qualified and in use |
| code_valid | output | 1 | The internal setting has been fixed for this enable |
| code_src | output | 1 | 1 = setting decoded from sync, 0 = from strap |
| freq_code | output | 3 | Internal oscillator setting, 0 (500 kHz) to 4 (2200 kHz) |

## Verification
The hardest situation to reach from the ports is the one where enable and the start of a legal sync are ordered so that the first gate window is fully covered by sync edges. That ordering is what selects decoding over the strap. The stimulus starts a sync clock at a chosen frequency a few hundred cycles before raising `en`, with `strap_sel` set to an unrelated random code. This makes any leak of the strap into `freq_code` visible. Frequencies are drawn from directed bin centres, from two boundary bands and from seeded random values. Each check accepts both neighbouring codes only inside a boundary band.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    localparam int CNT_W  = 16;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        F500  = 3'd0,
        F750  = 3'd1,
        F1000 = 3'd2,
        F1500 = 3'd3,
        F2200 = 3'd4
    } fcode_e;

    // Edge-count thresholds for one gate window
    typedef struct packed {
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] b1;
        logic [CNT_W-1:0] b2;
        logic [CNT_W-1:0] b3;
        logic [CNT_W-1:0] b4;
        logic [CNT_W-1:0] hi;
    } bins_t;

    typedef struct packed {
        logic   ok;
        fcode_e code;
    } meas_t;

    // Rounded number of edges a khz clock produces in gate reference cycles
    function automatic logic [CNT_W-1:0] khz_to_count(input longint khz,
                                                      input longint gate,
                                                      input longint ref_khz);
        longint c;
        c = (khz * gate + ref_khz / 2) / ref_khz;
        if (c > longint'((1 << CNT_W) - 1))
            c = longint'((1 << CNT_W) - 1);
        return c[CNT_W-1:0];
    endfunction

    function automatic meas_t classify(input logic [CNT_W-1:0] n, input bins_t b);
        meas_t r;
        r.ok = (n >= b.lo) && (n <= b.hi);
        if (n < b.b1)      r.code = F500;
        else if (n < b.b2) r.code = F750;
        else if (n < b.b3) r.code = F1000;
        else if (n < b.b4) r.code = F1500;
        else               r.code = F2200;
        return r;
    endfunction

    function automatic fcode_e strap_to_code(input logic [CODE_W-1:0] s);
        fcode_e c;
        case (s)
            3'd0:    c = F500;
            3'd1:    c = F750;
            3'd2:    c = F1000;
            3'd3:    c = F1500;
            default: c = F2200;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sfd_edge_sync.sv
module sfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level_o,
    output logic rise_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], async_in};
    end

    assign level_o = sh[STAGES-1];
    assign rise_o  = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/sfd_gate_meter.sv
module sfd_gate_meter
    import sfd_pkg::*;
#(
    parameter int GATE_CYCLES = 12500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             rise,
    output logic             win_done,
    output logic [CNT_W-1:0] win_count
);
    localparam int GW = $clog2(GATE_CYCLES + 1);

    logic [GW-1:0]    tmr;
    logic [CNT_W-1:0] acc;
    logic [CNT_W-1:0] acc_inc;

    // Saturating increment: the count never wraps past all ones
    assign acc_inc = (rise && acc != '1) ? acc + 1'b1 : acc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tmr       <= '0;
            acc       <= '0;
            win_done  <= 1'b0;
            win_count <= '0;
        end else begin
            win_done <= 1'b0;
            if (tmr == GW'(GATE_CYCLES - 1)) begin
                tmr       <= '0;
                acc       <= '0;
                win_done  <= 1'b1;
                win_count <= acc_inc;
            end else begin
                tmr <= tmr + 1'b1;
                acc <= acc_inc;
            end
        end
    end

    // R6: the window-done strobe is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        win_done |=> !win_done);

endmodule

// File: rtl/sfd_presence.sv
module sfd_presence #(
    parameter int TIMEOUT_CYCLES = 625,
    parameter int QUAL_WINDOWS   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic rise,
    input  logic win_done,
    input  logic win_ok,
    output logic present
);
    localparam int IW = $clog2(TIMEOUT_CYCLES + 1);
    localparam int SW = $clog2(QUAL_WINDOWS + 1);

    logic [IW-1:0] idle;
    logic [SW-1:0] streak;
    logic [SW-1:0] streak_n;
    logic          starved;

    assign starved = (idle == IW'(TIMEOUT_CYCLES));

    always_comb begin
        streak_n = streak;
        if (starved)
            streak_n = '0;
        else if (win_done)
            streak_n = !win_ok ? '0 :
                       (streak == SW'(QUAL_WINDOWS)) ? streak : streak + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            idle    <= '0;
            streak  <= '0;
            present <= 1'b0;
        end else begin
            idle    <= rise ? '0 : (starved ? idle : idle + 1'b1);
            streak  <= streak_n;
            present <= (streak_n == SW'(QUAL_WINDOWS));
        end
    end

    // R2: presence only ever starts right after a window closes
    p_rise_on_window_r2: assert property (@(posedge clk) disable iff (rst || !run)
        $rose(present) |-> $past(win_done));

    // R3: an edge-starved input drops presence on the next cycle
    p_starve_drop_r3: assert property (@(posedge clk) disable iff (rst || !run)
        starved |=> !present);

endmodule

// File: rtl/sync_freq_decoder.sv
module sync_freq_decoder
    import sfd_pkg::*;
#(
    parameter int REF_KHZ      = 125000,
    parameter int GATE_CYCLES  = 12500,
    parameter int MIN_KHZ      = 400,
    parameter int MAX_KHZ      = 2640,
    parameter int EDGE1_KHZ    = 600,
    parameter int EDGE2_KHZ    = 857,
    parameter int EDGE3_KHZ    = 1200,
    parameter int EDGE4_KHZ    = 1810,
    parameter int SYNC_STAGES  = 2,
    parameter int QUAL_WINDOWS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sync_in,
    input  logic              int_osc,
    input  logic [CODE_W-1:0] strap_sel,
    output logic              sw_clk,
    output logic              sync_active,
    output logic              code_valid,
    output logic              code_src,
    output logic [CODE_W-1:0] freq_code
);
    localparam int TIMEOUT_CYCLES = 2 * REF_KHZ / MIN_KHZ;

    localparam bins_t BINS = '{
        lo: khz_to_count(longint'(MIN_KHZ),   longint'(GATE_CYCLES), longint'(REF_KHZ)),
        b1: khz_to_count(longint'(EDGE1_KHZ), longint'(GATE_CYCLES), longint'(REF_KHZ)),
        b2: khz_to_count(longint'(EDGE2_KHZ), longint'(GATE_CYCLES), longint'(REF_KHZ)),
        b3: khz_to_count(longint'(EDGE3_KHZ), longint'(GATE_CYCLES), longint'(REF_KHZ)),
        b4: khz_to_count(longint'(EDGE4_KHZ), longint'(GATE_CYCLES), longint'(REF_KHZ)),
        hi: khz_to_count(longint'(MAX_KHZ),   longint'(GATE_CYCLES), longint'(REF_KHZ))
    };

    logic             sync_lvl;
    logic             sync_rise;
    logic             win_done;
    logic [CNT_W-1:0] win_count;
    meas_t            meas;
    logic             present;
    fcode_e           code_q;

    sfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sync_in),
        .level_o  (sync_lvl),
        .rise_o   (sync_rise)
    );

    sfd_gate_meter #(.GATE_CYCLES(GATE_CYCLES)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .run       (en),
        .rise      (sync_rise),
        .win_done  (win_done),
        .win_count (win_count)
    );

    assign meas = classify(win_count, BINS);

    sfd_presence #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
        .QUAL_WINDOWS   (QUAL_WINDOWS)
    ) u_presence (
        .clk      (clk),
        .rst      (rst),
        .run      (en),
        .rise     (sync_rise),
        .win_done (win_done),
        .win_ok   (meas.ok),
        .present  (present)
    );

    // Internal setting fixed once, at the first window after enable
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            code_q     <= F500;
            code_valid <= 1'b0;
            code_src   <= 1'b0;
        end else if (win_done && !code_valid) begin
            code_valid <= 1'b1;
            if (meas.ok) begin
                code_q   <= meas.code;
                code_src <= 1'b1;
            end else begin
                code_q   <= strap_to_code(strap_sel);
                code_src <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sw_clk <= 1'b0;
        else     sw_clk <= present ? sync_lvl : int_osc;
    end

    assign sync_active = present;
    assign freq_code   = code_q;

    // R10: a fixed setting never moves while enabled
    p_code_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (code_valid && $past(code_valid)) |-> ($stable(freq_code) && $stable(code_src)));

    // R6: the setting becomes valid only on a window boundary
    p_latch_at_window_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(code_valid) |-> $past(win_done));

    // R7: only the five defined codes can appear
    p_code_legal_r7: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> (freq_code <= 3'd4));

    // R1: presence requires enable on the previous cycle
    p_active_needs_en_r1: assert property (@(posedge clk) disable iff (rst)
        sync_active |-> $past(en));

endmodule

// File: tb/tb_sync_freq_decoder.sv
`timescale 1ns/1ps
module tb_sync_freq_decoder;

    localparam int GATE    = 5000;
    localparam int TIMEOUT = 2 * 125000 / 400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       sync_in = 1'b0;
    logic       int_osc = 1'b0;
    logic [2:0] strap_sel = 3'd0;
    logic       sw_clk, sync_active, code_valid, code_src;
    logic [2:0] freq_code;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    bit  sync_on  = 1'b0;
    real half_ns  = 500.0;

    always #4 clk = ~clk;

    always begin
        if (sync_on) begin
            #(half_ns);
            sync_in = ~sync_in;
        end else begin
            sync_in = 1'b0;
            #5;
        end
    end

    sync_freq_decoder #(.GATE_CYCLES(GATE)) dut (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .sync_in     (sync_in),
        .int_osc     (int_osc),
        .strap_sel   (strap_sel),
        .sw_clk      (sw_clk),
        .sync_active (sync_active),
        .code_valid  (code_valid),
        .code_src    (code_src),
        .freq_code   (freq_code)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Exact code for a sync frequency (R7)
    function automatic int exact_code(input int khz);
        if (khz < 600)  return 0;
        if (khz < 857)  return 1;
        if (khz < 1200) return 2;
        if (khz < 1810) return 3;
        return 4;
    endfunction

    // Lower neighbour allowed inside a boundary band (R8), else -1
    function automatic int band_low(input int khz);
        if (khz >= 570  && khz <= 630)  return 0;
        if (khz >= 814  && khz <= 900)  return 1;
        if (khz >= 1140 && khz <= 1260) return 2;
        if (khz >= 1736 && khz <= 1884) return 3;
        return -1;
    endfunction

    function automatic bit code_ok(input int code, input int khz);
        int lo;
        lo = band_low(khz);
        if (lo < 0) return code == exact_code(khz);
        return (code == lo) || (code == lo + 1);
    endfunction

    task automatic start_sync(input int khz);
        half_ns = 500000.0 / real'(khz);
        sync_on = 1'b1;
    endtask

    task automatic sync_first(input int khz);
        int st;
        st = int'($urandom_range(7, 0));
        strap_sel = 3'(st);
        start_sync(khz);
        step(400);
        en = 1'b1;
        step(GATE + 1);
        check(code_valid == 1'b1, "R6 valid after first window", int'(code_valid), 1);
        check(code_src == 1'b1, "R11 decoded source", int'(code_src), 1);
        check(code_ok(int'(freq_code), khz), $sformatf("R7/R8 decode %0d kHz", khz),
              int'(freq_code), exact_code(khz));
        check(sync_active == 1'b0, "R2 not active after one window", int'(sync_active), 0);
        strap_sel = ~strap_sel;
        step(GATE + 2);
        check(sync_active == 1'b1, "R2 active after two windows", int'(sync_active), 1);
        check(code_ok(int'(freq_code), khz), "R10 R11 code held, strap ignored",
              int'(freq_code), exact_code(khz));
        sync_on = 1'b0;
        en = 1'b0;
        step(100);
    endtask

    initial begin
        int edges;
        logic prev;
        void'($urandom(32'd20240117));

        // R1: reset state
        step(5);
        check(freq_code == 3'd0, "R1 reset freq_code", int'(freq_code), 0);
        check(code_valid == 1'b0, "R1 reset code_valid", int'(code_valid), 0);
        check(sync_active == 1'b0, "R1 reset sync_active", int'(sync_active), 0);
        check(sw_clk == 1'b0, "R1 reset sw_clk", int'(sw_clk), 0);
        rst = 1'b0;
        step(2);

        // R9 / R6: enable with no sync, strap picks the setting
        strap_sel = 3'd3;
        en = 1'b1;
        step(GATE);
        check(code_valid == 1'b0, "R6 not valid before window end", int'(code_valid), 0);
        step(1);
        check(code_valid == 1'b1, "R6 valid at window end", int'(code_valid), 1);
        check(freq_code == 3'd3, "R9 strap code", int'(freq_code), 3);
        check(code_src == 1'b0, "R9 strap source", int'(code_src), 0);

        // R2 / R10: sync appears later, setting stays the strap value
        strap_sel = 3'd1;
        start_sync(1000);
        step(3 * GATE + 20);
        check(sync_active == 1'b1, "R2 active after late sync", int'(sync_active), 1);
        check(freq_code == 3'd3, "R10 code held when sync appears", int'(freq_code), 3);

        // R5: sw_clk follows a 1 MHz sync, about 8 edges in 1000 cycles
        edges = 0;
        prev = sw_clk;
        for (int i = 0; i < 1000; i++) begin
            step(1);
            if (sw_clk && !prev) edges++;
            prev = sw_clk;
        end
        check(edges >= 7 && edges <= 9, "R5 sw_clk follows sync", edges, 8);

        // R3: sync removed
        sync_on = 1'b0;
        step(TIMEOUT + 100);
        check(sync_active == 1'b0, "R3 sync lost", int'(sync_active), 0);
        check(freq_code == 3'd3, "R10 code held after loss", int'(freq_code), 3);
        check(code_src == 1'b0, "R10 source held after loss", int'(code_src), 0);

        // R5: fallback path is the internal oscillator
        int_osc = 1'b1;
        step(2);
        check(sw_clk == 1'b1, "R5 sw_clk follows int_osc high", int'(sw_clk), 1);
        int_osc = 1'b0;
        step(2);
        check(sw_clk == 1'b0, "R5 sw_clk follows int_osc low", int'(sw_clk), 0);

        // R1: disable clears the setting
        en = 1'b0;
        step(2);
        check(code_valid == 1'b0, "R1 disable clears valid", int'(code_valid), 0);
        check(freq_code == 3'd0, "R1 disable clears code", int'(freq_code), 0);

        // R9: strap values above 4 saturate
        strap_sel = 3'd6;
        en = 1'b1;
        step(GATE + 1);
        check(freq_code == 3'd4, "R9 strap saturation", int'(freq_code), 4);
        en = 1'b0;
        step(10);

        // R4: above-range sync at enable acts as no sync
        strap_sel = 3'd2;
        start_sync(3000);
        step(400);
        en = 1'b1;
        step(GATE + 1);
        check(code_src == 1'b0, "R4 high freq not decoded", int'(code_src), 0);
        check(freq_code == 3'd2, "R4 strap used for high freq", int'(freq_code), 2);
        step(2 * GATE);
        check(sync_active == 1'b0, "R4 high freq never active", int'(sync_active), 0);

        // R4: below-range sync
        start_sync(300);
        step(2 * GATE + 10);
        check(sync_active == 1'b0, "R4 low freq never active", int'(sync_active), 0);
        sync_on = 1'b0;
        en = 1'b0;
        step(100);

        // R7 / R8 / R11: sync present at enable, directed and random
        sync_first(480);
        sync_first(700);
        sync_first(1000);
        sync_first(1500);
        sync_first(2200);
        sync_first(600);
        sync_first(1810);
        for (int k = 0; k < 2; k++)
            sync_first(int'($urandom_range(2600, 420)));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule